// File: doc/BRIEF.md
# Cascaded Multi-Bank Interrupt Controller

This block gathers 96 level-sensitive interrupt sources into one resolve result for a host CPU. The sources sit in three 32-bit banks: a low main bank, a high main bank and a general-purpose pin bank. The pin bank is not searched on its own. It folds into four summary bits of the high bank, and it is searched only after one of those summary bits has won. Software reads a resolve register and gets the winning interrupt number or a spurious code. Reading that register also retires a winning pin bit.

A second CPU port gets only the doorbell source. That source is bit 28 of the low bank, and the port passes it through its own mask register. Masks are plain 32-bit registers written over a simple single-cycle register bus. Main-bank cause bits are the live source levels and are not stored. Pin cause bits are latched, and software clears them by writing 0.

Top module: `cirq_ctrl`

## Requirements
- R1: Low bank bit b resolves to number b, high bank bit b to 32+b, and pin cause bit k to 64+k.
- R2: Only low bits in the set 0x3DFFFFFE and high bits in the set 0x1F0003F7 can win. Low bits 0, 25, 30 and 31 and high bits 3, 10 to 23 and 29 to 31 never win. A candidate must also be set in its CPU0 mask register.
- R3: Any enabled low bit wins over any high bit. Within a bank, the lowest enabled bit index wins.
- R4: High bank bits 24 to 27 are summary bits. Bit 24+g is the OR of pin cause bits 8g to 8g+7, and hi_src_i bits 24 to 27 are ignored. When a summary bit wins, the result is 64 plus the lowest pin cause bit that is also set in the pin mask.
- R5: CPU0 resolve returns 0xFFFFFFFE and irq0_o is low in two cases: no bank has an enabled candidate, or a summary bit wins and no pin cause bit is enabled. Otherwise irq0_o is high.
- R6: A pin cause bit is set after any rising clock edge at which its pin_i bit is high. Writing the pin cause register clears each bit written as 0 and leaves each bit written as 1 unchanged. A bit whose pin is still high stays set.
- R7: A read of the CPU0 resolve register (bus_re_i high) that delivers a pin number clears that pin cause bit at the same clock edge.
- R8: The CPU1 resolve register returns 28 and irq1_o is high exactly when lo_src_i[28] and bit 28 of the CPU1 mask are both set. Otherwise it returns 0xFFFFFFFF with irq1_o low, whatever other sources are active.
- R9: After reset the high mask is 0x0F000000, the other masks and the pin cause are 0, and neither irq output is asserted.
- R10: Register addresses are 0 low mask, 1 high mask, 2 pin mask, 3 pin cause, 4 CPU1 mask, 5 CPU0 resolve and 6 CPU1 resolve. A write to a mask takes effect at the clock edge, and the mask reads back the written value. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lo_src_i | input | 32 | Low main bank source levels |
| hi_src_i | input | 32 | High main bank source levels (bits 24 to 27 unused) |
| pin_i | input | 32 | General-purpose pin source levels |
| bus_addr_i | input | 3 | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe (side effect on CPU0 resolve) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data |
| irq0_o | output | 1 | CPU0 interrupt request |
| irq1_o | output | 1 | CPU1 interrupt request |

## Verification
The bench builds the block with its default parameters: valid filters 0x3DFFFFFE and 0x1F0003F7, a summary field of four 8-pin groups at bits 24 to 27, and the doorbell at bit 28. With these values every filtered-out bit position can be driven. The bench also reaches the boundary between the summary field and high bit 28. One pin group is made to win the summary while a pin in another group is the only enabled one. The doorbell is checked against unrelated low sources while the CPU1 mask is all ones.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int BANK_W = 32;
  localparam int IDX_W  = $clog2(BANK_W);
  localparam logic [BANK_W-1:0] CODE_SPURIOUS = 32'hFFFF_FFFE;
  localparam logic [BANK_W-1:0] CODE_NONE     = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    A_LO_MASK   = 3'd0,
    A_HI_MASK   = 3'd1,
    A_PIN_MASK  = 3'd2,
    A_PIN_CAUSE = 3'd3,
    A_CPU1_MASK = 3'd4,
    A_RES0      = 3'd5,
    A_RES1      = 3'd6,
    A_RSVD      = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/ic_pick.sv
module ic_pick #(
  parameter int W  = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  req_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    hit_o = |req_i;
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/ic_pin_bank.sv
module ic_pin_bank #(
  parameter int W    = 32,
  parameter int GRPS = 4,
  localparam int GW = W / GRPS,
  localparam int IW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  pin_i,
  input  logic          wr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          ack_i,
  input  logic [IW-1:0] ack_idx_i,
  output logic [W-1:0]  cause_o,
  output logic [GRPS-1:0] summary_o
);
  logic [W-1:0] cause_q, cause_d;

  always_comb begin
    cause_d = cause_q;
    if (wr_i)  cause_d = cause_d & wdata_i;   // write 0 clears
    if (ack_i) cause_d[ack_idx_i] = 1'b0;
    cause_d = cause_d | pin_i;                // level re-sets
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= cause_d;
  end

  for (genvar g = 0; g < GRPS; g++) begin : g_sum
    assign summary_o[g] = |cause_q[g*GW +: GW];
  end

  assign cause_o = cause_q;

  p_w1_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !ack_i) |=> ((cause_q & $past(wdata_i & cause_q)) == $past(wdata_i & cause_q)));
  p_set_by_pin_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(pin_i)) == '0));
  p_ack_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !pin_i[ack_idx_i]) |=> !cause_q[$past(ack_idx_i)]);
endmodule

// File: rtl/ic_resolver.sv
module ic_resolver
  import ic_pkg::*;
#(
  parameter logic [BANK_W-1:0] LO_VALID = 32'h3DFF_FFFE,
  parameter logic [BANK_W-1:0] HI_VALID = 32'h1F00_03F7,
  parameter int SUM_LSB  = 24,
  parameter int PIN_GRPS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] lo_cause_i,
  input  logic [BANK_W-1:0] hi_cause_i,
  input  logic [PIN_GRPS-1:0] pin_sum_i,
  input  logic [BANK_W-1:0] pin_cause_i,
  input  logic [BANK_W-1:0] lo_mask_i,
  input  logic [BANK_W-1:0] hi_mask_i,
  input  logic [BANK_W-1:0] pin_mask_i,
  output logic              irq_o,
  output logic [BANK_W-1:0] code_o,
  output logic              pin_win_o,
  output logic [IDX_W-1:0]  pin_idx_o
);
  localparam logic [IDX_W-1:0] SUM_FIRST = IDX_W'(SUM_LSB);
  localparam logic [IDX_W-1:0] SUM_LAST  = IDX_W'(SUM_LSB + PIN_GRPS - 1);

  logic [BANK_W-1:0] hi_cause, lo_req, hi_req, pin_req;
  logic lo_hit, hi_hit, pin_hit;
  logic [IDX_W-1:0] lo_idx, hi_idx, pin_idx;

  always_comb begin
    hi_cause = hi_cause_i;
    hi_cause[SUM_LSB +: PIN_GRPS] = pin_sum_i;
  end

  assign lo_req  = lo_cause_i & LO_VALID & lo_mask_i;
  assign hi_req  = hi_cause & HI_VALID & hi_mask_i;
  assign pin_req = pin_cause_i & pin_mask_i;

  ic_pick #(.W(BANK_W)) u_lo  (.req_i(lo_req),  .hit_o(lo_hit),  .idx_o(lo_idx));
  ic_pick #(.W(BANK_W)) u_hi  (.req_i(hi_req),  .hit_o(hi_hit),  .idx_o(hi_idx));
  ic_pick #(.W(BANK_W)) u_pin (.req_i(pin_req), .hit_o(pin_hit), .idx_o(pin_idx));

  always_comb begin
    irq_o     = 1'b0;
    code_o    = CODE_SPURIOUS;
    pin_win_o = 1'b0;
    if (lo_hit) begin
      irq_o  = 1'b1;
      code_o = BANK_W'(lo_idx);
    end else if (hi_hit) begin
      if (hi_idx >= SUM_FIRST && hi_idx <= SUM_LAST) begin
        if (pin_hit) begin
          irq_o     = 1'b1;
          pin_win_o = 1'b1;
          code_o    = BANK_W'(pin_idx) + BANK_W'(2 * BANK_W);
        end
      end else begin
        irq_o  = 1'b1;
        code_o = BANK_W'(hi_idx) + BANK_W'(BANK_W);
      end
    end
  end

  assign pin_idx_o = pin_idx;

  p_lo_win_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && code_o < BANK_W'(BANK_W)) |->
      (lo_cause_i[code_o[IDX_W-1:0]] && LO_VALID[code_o[IDX_W-1:0]] && lo_mask_i[code_o[IDX_W-1:0]]));
  p_pin_win_enabled_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_win_o |-> (pin_cause_i[pin_idx_o] && pin_mask_i[pin_idx_o] && !(|lo_req)));
  p_low_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lo_req) |-> (irq_o && code_o < BANK_W'(BANK_W)));
endmodule

// File: rtl/cirq_ctrl.sv
module cirq_ctrl
  import ic_pkg::*;
#(
  parameter logic [BANK_W-1:0] LO_VALID    = 32'h3DFF_FFFE,
  parameter logic [BANK_W-1:0] HI_VALID    = 32'h1F00_03F7,
  parameter logic [BANK_W-1:0] HI_MASK_RST = 32'h0F00_0000,
  parameter int SUM_LSB  = 24,
  parameter int PIN_GRPS = 4,
  parameter int DOORBELL = 28
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] lo_src_i,
  input  logic [31:0] hi_src_i,
  input  logic [31:0] pin_i,
  input  logic [2:0]  bus_addr_i,
  input  logic        bus_we_i,
  input  logic        bus_re_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        irq0_o,
  output logic        irq1_o
);
  logic [BANK_W-1:0] lo_mask_q, hi_mask_q, pin_mask_q, cpu1_mask_q;
  logic [BANK_W-1:0] pin_cause, res0, res1;
  logic [PIN_GRPS-1:0] pin_sum;
  logic pin_win, pin_ack, pin_wr, db_hit;
  logic [IDX_W-1:0] pin_idx;
  reg_addr_e addr;

  assign addr = reg_addr_e'(bus_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_mask_q   <= '0;
      hi_mask_q   <= HI_MASK_RST;
      pin_mask_q  <= '0;
      cpu1_mask_q <= '0;
    end else if (bus_we_i) begin
      case (addr)
        A_LO_MASK:   lo_mask_q   <= bus_wdata_i;
        A_HI_MASK:   hi_mask_q   <= bus_wdata_i;
        A_PIN_MASK:  pin_mask_q  <= bus_wdata_i;
        A_CPU1_MASK: cpu1_mask_q <= bus_wdata_i;
        default: ;
      endcase
    end
  end

  assign pin_wr  = bus_we_i && addr == A_PIN_CAUSE;
  assign pin_ack = bus_re_i && addr == A_RES0 && pin_win;

  ic_pin_bank #(.W(BANK_W), .GRPS(PIN_GRPS)) u_pins (
    .clk_i, .rst_ni, .pin_i,
    .wr_i(pin_wr), .wdata_i(bus_wdata_i),
    .ack_i(pin_ack), .ack_idx_i(pin_idx),
    .cause_o(pin_cause), .summary_o(pin_sum)
  );

  ic_resolver #(.LO_VALID(LO_VALID), .HI_VALID(HI_VALID),
                .SUM_LSB(SUM_LSB), .PIN_GRPS(PIN_GRPS)) u_res0 (
    .clk_i, .rst_ni,
    .lo_cause_i(lo_src_i), .hi_cause_i(hi_src_i),
    .pin_sum_i(pin_sum), .pin_cause_i(pin_cause),
    .lo_mask_i(lo_mask_q), .hi_mask_i(hi_mask_q), .pin_mask_i(pin_mask_q),
    .irq_o(irq0_o), .code_o(res0), .pin_win_o(pin_win), .pin_idx_o(pin_idx)
  );

  // second CPU: doorbell only
  assign db_hit = lo_src_i[DOORBELL] & cpu1_mask_q[DOORBELL];
  assign irq1_o = db_hit;
  assign res1   = db_hit ? BANK_W'(DOORBELL) : CODE_NONE;

  always_comb begin
    case (addr)
      A_LO_MASK:   bus_rdata_o = lo_mask_q;
      A_HI_MASK:   bus_rdata_o = hi_mask_q;
      A_PIN_MASK:  bus_rdata_o = pin_mask_q;
      A_PIN_CAUSE: bus_rdata_o = pin_cause;
      A_CPU1_MASK: bus_rdata_o = cpu1_mask_q;
      A_RES0:      bus_rdata_o = res0;
      A_RES1:      bus_rdata_o = res1;
      default:     bus_rdata_o = '0;
    endcase
  end

  p_cpu1_doorbell_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq1_o |-> (lo_src_i[DOORBELL] && cpu1_mask_q[DOORBELL]));
  p_mask_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && addr == A_LO_MASK) |=> (lo_mask_q == $past(bus_wdata_i)));
endmodule

// File: tb/sim_cirq_ctrl.sv
`timescale 1ns/1ps
module sim_cirq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] lo_src = '0, hi_src = '0, pin = '0, wdata = '0;
  logic [2:0] addr = '0;
  logic we = 1'b0, re = 1'b0;
  logic [31:0] rdata;
  logic irq0, irq1;
  int n_chk = 0, n_fail = 0;

  localparam logic [31:0] SPUR = 32'hFFFF_FFFE;
  localparam logic [31:0] NONE = 32'hFFFF_FFFF;

  always #2.5 clk = ~clk;

  cirq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .lo_src_i(lo_src), .hi_src_i(hi_src),
    .pin_i(pin), .bus_addr_i(addr), .bus_we_i(we), .bus_re_i(re),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq0_o(irq0), .irq1_o(irq1)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse_pins(logic [31:0] p);
    @(negedge clk); pin = p;
    @(negedge clk); pin = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, d); chk("R9 lo mask", d, 32'h0);
    rd(3'd1, d); chk("R9 hi mask", d, 32'h0F00_0000);
    rd(3'd2, d); chk("R9 pin mask", d, 32'h0);
    rd(3'd3, d); chk("R9 pin cause", d, 32'h0);
    rd(3'd4, d); chk("R9 cpu1 mask", d, 32'h0);
    rd(3'd5, d); chk("R9 res0", d, SPUR);
    rd(3'd6, d); chk("R9 res1", d, NONE);
    chk("R9 irq0", 32'(irq0), 32'h0);
    chk("R9 irq1", 32'(irq1), 32'h0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(3'd0, 32'hA5A5_1234); rd(3'd0, d); chk("R10 lo mask rb", d, 32'hA5A5_1234);
    wr(3'd2, 32'h0F0F_00FF); rd(3'd2, d); chk("R10 pin mask rb", d, 32'h0F0F_00FF);
    wr(3'd4, 32'h1234_5678); rd(3'd4, d); chk("R10 cpu1 mask rb", d, 32'h1234_5678);
    rd(3'd7, d); chk("R10 unused addr", d, 32'h0);
    wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'h0); wr(3'd4, 32'h0);
  endtask

  task automatic t_low();
    logic [31:0] d;
    @(negedge clk); lo_src = (32'h1 << 9) | (32'h1 << 5);
    rd(3'd5, d); chk("R3 lowest low bit", d, 32'd5);
    chk("R5 irq0 high", 32'(irq0), 32'h1);
    @(negedge clk); lo_src = 32'h1;
    rd(3'd5, d); chk("R2 low bit0 filtered", d, SPUR);
    chk("R5 irq0 low", 32'(irq0), 32'h0);
    @(negedge clk); lo_src = (32'h1 << 25) | (32'h1 << 26) | (32'h1 << 31);
    rd(3'd5, d); chk("R2 low bit25 skipped", d, 32'd26);
    @(negedge clk); lo_src = 32'h1 << 7; hi_src = 32'h1 << 4;
    rd(3'd5, d); chk("R3 low over high", d, 32'd7);
    wr(3'd0, 32'hFFFF_FF7F);
    rd(3'd5, d); chk("R2 low masked off", d, 32'd36);
    wr(3'd0, 32'hFFFF_FFFF);
    @(negedge clk); lo_src = '0; hi_src = '0;
  endtask

  task automatic t_high();
    logic [31:0] d;
    @(negedge clk); hi_src = 32'h1 << 3;
    rd(3'd5, d); chk("R2 high bit3 filtered", d, SPUR);
    @(negedge clk); hi_src = (32'h1 << 3) | (32'h1 << 4);
    rd(3'd5, d); chk("R1 high bit4", d, 32'd36);
    @(negedge clk); hi_src = 32'h1 << 28;
    rd(3'd5, d); chk("R1 high bit28", d, 32'd60);
    @(negedge clk); hi_src = (32'h1 << 24) | (32'h1 << 29);
    rd(3'd5, d); chk("R4 summary input ignored", d, SPUR);
    @(negedge clk); hi_src = '0;
  endtask

  task automatic t_pins();
    logic [31:0] d;
    wr(3'd2, 32'hFFFF_FFFF);
    pulse_pins(32'h1 << 10);
    rd(3'd3, d); chk("R6 pin latched", d, 32'h1 << 10);
    rd(3'd5, d); chk("R1 pin10 number", d, 32'd74);
    @(negedge clk); lo_src = 32'h1 << 2;
    rd(3'd5, d); chk("R3 low over pin", d, 32'd2);
    @(negedge clk); lo_src = '0; addr = 3'd5; re = 1'b1; #1 d = rdata;
    chk("R7 read delivers pin", d, 32'd74);
    @(negedge clk); re = 1'b0;
    rd(3'd3, d); chk("R7 pin auto cleared", d, 32'h0);
    pulse_pins((32'h1 << 3) | (32'h1 << 20));
    rd(3'd5, d); chk("R3 lowest pin", d, 32'd67);
    wr(3'd2, 32'hFFFF_FFF7);
    rd(3'd5, d); chk("R4 other group pin", d, 32'd84);
    @(negedge clk); hi_src = 32'h1 << 4;
    rd(3'd5, d); chk("R3 high bit4 before summary", d, 32'd36);
    @(negedge clk); hi_src = '0;
    wr(3'd2, 32'h0);
    rd(3'd5, d); chk("R5 summary no enabled pin", d, SPUR);
    chk("R5 irq0 low on spurious", 32'(irq0), 32'h0);
    wr(3'd3, 32'hFFFF_FFF7);
    rd(3'd3, d); chk("R6 write0 clears", d, 32'h1 << 20);
    @(negedge clk); pin = 32'h1 << 5;
    wr(3'd3, 32'h0);
    rd(3'd3, d); chk("R6 held level stays", d, 32'h1 << 5);
    @(negedge clk); pin = '0;
    wr(3'd3, 32'h0);
    rd(3'd3, d); chk("R6 cleared after release", d, 32'h0);
  endtask

  task automatic t_cpu1();
    logic [31:0] d;
    @(negedge clk); lo_src = 32'h1 << 28;
    rd(3'd6, d); chk("R8 doorbell masked", d, NONE);
    chk("R8 irq1 low", 32'(irq1), 32'h0);
    wr(3'd4, 32'h1 << 28);
    rd(3'd6, d); chk("R8 doorbell pending", d, 32'd28);
    chk("R8 irq1 high", 32'(irq1), 32'h1);
    wr(3'd4, 32'hFFFF_FFFF);
    @(negedge clk); lo_src = 32'h1 << 3;
    rd(3'd6, d); chk("R8 other source ignored", d, NONE);
    chk("R8 irq1 low other", 32'(irq1), 32'h0);
    @(negedge clk); lo_src = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_low();
    t_high();
    t_pins();
    t_cpu1();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule